// File: doc/BRIEF.md
# EDID Register Read Controller

This block sits on a host register bus and behaves like a display-data-channel controller that only ever reads an EDID. Nothing is driven onto a real two-wire bus. A 128-byte EDID image is held in local storage, filled through a byte-wide load port. The host picks a display port, writes a command word, and then reads the data register. Each data read returns up to four EDID bytes and advances an internal read pointer.

The controller keeps a bus phase (idle, data or wait) and a small set of status flags. It also models an in-use semaphore that software takes by reading status and frees by writing it. An interrupt-clear bit in the command word holds the command register until software writes the bit back to zero, and that write resets the controller. Only target address 0x50 is answered. Other targets get zero bytes.

Register offsets on `busAddr` are: 0 port select, 1 command, 2 status, 3 data. Command fields are:
- bit 0: read direction
- bits 7:1: target address
- bits 15:8: start index
- bits 24:16: byte count
- bits 27:25: cycle type. Its bit 0 requests a data phase, bit 1 enables the index and bit 2 requests a stop.
- bit 30: software-ready
- bit 31: interrupt-clear

Status bits are:
- bit 0: hardware-ready
- bit 1: wait flag
- bit 2: error
- bit 3: active
- bit 4: in-use
- bits 9:8: phase, where 0 is idle, 1 is data and 2 is wait

Top module: `ddc_edid_ctrl`

## Requirements
- R1: After reset, status reads 0x005 (hardware-ready and error set, phase idle), and the select, command and data registers read 0.
- R2: Any write to port select (bits 2:0) sets the phase to idle and drops the read state. A value from 1 to NUM_PORTS also clears active and sets hardware-ready and the wait flag. It then clears the error bit and makes EDID available if that port's `portPresent` bit is set; otherwise it sets the error bit.
- R3: When interrupt-clear is not held, a command write is stored with bit 30 forced to 0, and read back unchanged otherwise.
- R4: A stored command whose cycle-type bit 0 is set puts the phase in data and sets active.
- R5: A cycle type of exactly 4 (stop only) takes effect only if the previously stored cycle type was nonzero. It then drops the read state, sets the phase to idle and clears active; otherwise it changes neither.
- R6: A data read, with direction bit 0 set in the stored command, returns min(4, count − pointer) bytes with the first byte in bits 7:0 and zero above. Each returned EDID byte advances the pointer. The start index is loaded into the pointer only when cycle-type bit 1 is set.
- R7: A data read that leaves 4 or fewer bytes sets the phase to idle when cycle-type bit 2 is set and to wait otherwise, then drops the read state. A data read with no bytes left returns the previous data value.
- R8: A byte taken when target 0x50 is not selected, when EDID is unavailable, or at pointer 128 or beyond reads as 0x00 and does not advance the pointer.
- R9: A status read returns the value before the read and then sets in-use. Writing status with bit 4 set clears in-use, and no other status bit can be written.
- R10: Writing a command with bit 31 set clears nothing but sets hardware-ready and holds the command register. While it is held, writes with bit 31 set are ignored. A write with bit 31 clear releases the hold and resets status to hardware-ready, plus error when no EDID is available, with phase idle.
- R11: Writes to the data register are ignored, and a data read with direction bit 0 clear returns the previous data value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read strobe |
| portPresent | input | NUM_PORTS | Display attached on each port, bit n-1 for port n |
| edidWe | input | 1 | EDID image byte write |
| edidAddr | input | EDID_AW | EDID image byte address |
| edidData | input | 8 | EDID image byte value |

## Verification
The properties take it for granted that the host issues at most one register access per cycle. They also assume `busAddr` and `busWdata` are only meaningful while `busValid` is high. The stimulus drives each access as a single-cycle strobe with idle cycles in between, so every strobe lines up with exactly one register action. The bench loads the EDID image before any command. It changes `portPresent` only while no transfer is in progress, because the port's presence is sampled only when port select is written.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam logic [1:0] REG_SEL  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int ST_INUSE  = 4;
  localparam int CMD_SWRDY = 30;
  localparam int CMD_ICLR  = 31;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  typedef struct packed {
    logic clrRead;
    logic ldCount;
    logic ldIndex;
    logic fetch;
    logic fetchOk;
  } dp_ctl_t;
endpackage

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter logic [6:0] TARGET_ADDR = 7'h50
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [1:0]           busAddr,
  input  logic [31:0]          busWdata,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 noneLeft,
  input  logic                 lastChunk,
  output dp_ctl_t              dpCtl,
  output logic [2:0]           selQ,
  output logic [31:0]          cmdQ,
  output logic [31:0]          statusQ
);
  logic hwRdy, waitF, errF, active, inUse;
  logic slaveSel, avail;
  logic [2:0] cycleQ;
  phase_t phase;

  logic wrSel, wrCmd, wrStat, rdStat, rdData;
  logic [2:0] selVal, cmdCyc;
  logic [7:0] presentPad;
  logic selValid, selHasDisp, holdClr, cmdLive, isStop, fetchGo;

  always_comb begin
    wrSel  = busValid && busWrite && (busAddr == REG_SEL);
    wrCmd  = busValid && busWrite && (busAddr == REG_CMD);
    wrStat = busValid && busWrite && (busAddr == REG_STAT);
    rdStat = busValid && !busWrite && (busAddr == REG_STAT);
    rdData = busValid && !busWrite && (busAddr == REG_DATA);

    selVal = busWdata[2:0];
    presentPad = '0;
    presentPad[NUM_PORTS:1] = portPresent;
    selValid   = (selVal != 3'd0) && (selVal <= 3'(NUM_PORTS));
    selHasDisp = selValid && presentPad[selVal];

    cmdCyc  = busWdata[27:25];
    holdClr = cmdQ[CMD_ICLR];
    cmdLive = wrCmd && !holdClr;
    isStop  = cmdLive && (cmdCyc == 3'b100) && (cmdQ[27:25] != 3'd0);
    fetchGo = rdData && cmdQ[0] && !noneLeft;

    dpCtl.clrRead = wrSel || isStop || (fetchGo && lastChunk);
    dpCtl.ldCount = cmdLive;
    dpCtl.ldIndex = cmdLive && cmdCyc[1];
    dpCtl.fetch   = fetchGo;
    dpCtl.fetchOk = slaveSel && avail;

    statusQ = {22'd0, phase, 3'd0, inUse, active, errF, waitF, hwRdy};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0; cmdQ <= '0;
      hwRdy <= 1'b1; waitF <= 1'b0; errF <= 1'b1; active <= 1'b0; inUse <= 1'b0;
      slaveSel <= 1'b0; avail <= 1'b0; cycleQ <= '0; phase <= PH_IDLE;
    end else begin
      if (wrSel) begin
        selQ <= selVal;
        slaveSel <= 1'b0; avail <= 1'b0; cycleQ <= '0; phase <= PH_IDLE;
        if (selValid) begin
          active <= 1'b0; hwRdy <= 1'b1; waitF <= 1'b1;
          errF   <= !selHasDisp;
          avail  <= selHasDisp;
        end
      end
      if (wrCmd && holdClr && !busWdata[CMD_ICLR]) begin
        cmdQ[CMD_ICLR] <= 1'b0;
        hwRdy <= 1'b1; waitF <= 1'b0; errF <= !avail;
        active <= 1'b0; inUse <= 1'b0; phase <= PH_IDLE;
      end
      if (cmdLive) begin
        cmdQ <= busWdata;
        cmdQ[CMD_SWRDY] <= 1'b0;
        if (busWdata[CMD_ICLR]) hwRdy <= 1'b1;
        if (busWdata[7:1] == TARGET_ADDR) slaveSel <= 1'b1;
        cycleQ <= cmdCyc;
        if (cmdCyc[0]) begin
          phase <= PH_DATA; active <= 1'b1;
        end
        if (isStop) begin
          slaveSel <= 1'b0; avail <= 1'b0; cycleQ <= '0;
          phase <= PH_IDLE; active <= 1'b0;
        end
      end
      if (rdStat) inUse <= 1'b1;
      if (wrStat && busWdata[ST_INUSE]) inUse <= 1'b0;
      if (fetchGo && lastChunk) begin
        phase <= cycleQ[2] ? PH_IDLE : PH_WAIT;
        slaveSel <= 1'b0; avail <= 1'b0; cycleQ <= '0;
      end
    end
  end
endmodule

// File: rtl/ddc_data.sv
module ddc_data
  import ddc_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int AW      = $clog2(DEPTH),
  parameter int CNT_W   = 9,
  parameter int PTR_W   = 8,
  parameter int LANES   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          dpCtl,
  input  logic [CNT_W-1:0] cntIn,
  input  logic [PTR_W-1:0] idxIn,
  input  logic             edidWe,
  input  logic [AW-1:0]    edidAddr,
  input  logic [7:0]       edidData,
  output logic             noneLeft,
  output logic             lastChunk,
  output logic [8*LANES-1:0] dataOut
);
  localparam int LW = CNT_W + 2;
  localparam int NW = $clog2(LANES) + 1;

  logic [7:0] mem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] ptr;
  logic [8*LANES-1:0] dataReg, fetchWord;
  logic signed [LW-1:0] leftS;
  logic [NW-1:0] nBytes;
  logic [LANES-1:0] laneOk;
  logic [NW-1:0] adv;

  always_ff @(posedge clk) begin
    if (edidWe) mem[edidAddr] <= edidData;
  end

  always_comb begin
    leftS = $signed({2'b00, count}) - $signed({{(LW-PTR_W){1'b0}}, ptr});
    noneLeft  = (leftS < 1);
    lastChunk = (leftS <= LANES);
    nBytes = (leftS > LANES) ? NW'(LANES) : leftS[NW-1:0];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PTR_W:0] laneAddr;
    assign laneAddr = {1'b0, ptr} + (PTR_W+1)'(i);
    assign laneOk[i] = dpCtl.fetchOk && (nBytes > NW'(i)) && (laneAddr < (PTR_W+1)'(DEPTH));
    assign fetchWord[8*i +: 8] = laneOk[i] ? mem[laneAddr[AW-1:0]] : 8'h00;
  end

  always_comb adv = NW'($countones(laneOk));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0; ptr <= '0; dataReg <= '0;
    end else begin
      if (dpCtl.fetch) begin
        dataReg <= fetchWord;
        ptr <= ptr + PTR_W'(adv);
      end
      if (dpCtl.ldCount) count <= cntIn;
      if (dpCtl.ldIndex) ptr <= idxIn;
      if (dpCtl.clrRead) begin
        count <= '0; ptr <= '0;
      end
    end
  end

  assign dataOut = dpCtl.fetch ? fetchWord : dataReg;
endmodule

// File: rtl/ddc_edid_ctrl.sv
module ddc_edid_ctrl
  import ddc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int EDID_DEPTH = 128,
  parameter int EDID_AW = $clog2(EDID_DEPTH),
  parameter logic [6:0] TARGET_ADDR = 7'h50
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [1:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 edidWe,
  input  logic [EDID_AW-1:0]   edidAddr,
  input  logic [7:0]           edidData
);
  dp_ctl_t dpCtl;
  logic noneLeft, lastChunk;
  logic [2:0] selQ;
  logic [31:0] cmdQ, statusQ, dataOut;

  ddc_ctrl #(.NUM_PORTS(NUM_PORTS), .TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .portPresent(portPresent),
    .noneLeft(noneLeft), .lastChunk(lastChunk), .dpCtl(dpCtl),
    .selQ(selQ), .cmdQ(cmdQ), .statusQ(statusQ)
  );

  ddc_data #(.DEPTH(EDID_DEPTH), .AW(EDID_AW), .CNT_W(9), .PTR_W(8), .LANES(4)) u_data (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .cntIn(busWdata[24:16]), .idxIn(busWdata[15:8]),
    .edidWe(edidWe), .edidAddr(edidAddr), .edidData(edidData),
    .noneLeft(noneLeft), .lastChunk(lastChunk), .dataOut(dataOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (busValid && !busWrite) begin
      case (busAddr)
        REG_SEL:  busRdata <= {29'd0, selQ};
        REG_CMD:  busRdata <= cmdQ;
        REG_STAT: busRdata <= statusQ;
        default:  busRdata <= dataOut;
      endcase
    end
  end
endmodule

// File: rtl/ddc_edid_chk.sv
module ddc_edid_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [1:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] cmdQ,
  input logic [31:0] statusQ
);
  logic cmdWr, statRd, statWr, selWr;
  assign cmdWr  = busValid && busWrite && busAddr == 2'd1;
  assign statRd = busValid && !busWrite && busAddr == 2'd2;
  assign statWr = busValid && busWrite && busAddr == 2'd2;
  assign selWr  = busValid && busWrite && busAddr == 2'd0;

  assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[9:8] != 2'b11);

  assert_data_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !cmdQ[31] && busWdata[25] |=> statusQ[3] && statusQ[9:8] == 2'b01);

  assert_cmd_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !cmdQ[31] |=> cmdQ == ($past(busWdata) & 32'hBFFF_FFFF));

  assert_inuse_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> statusQ[4]);

  assert_inuse_clr_R9: assert property (@(posedge clk) disable iff (!rstN)
    statWr && busWdata[4] |=> !statusQ[4]);

  assert_clr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdQ[31] && busWdata[31] |=> $stable(cmdQ));

  assert_sel_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    selWr |=> statusQ[9:8] == 2'b00);
endmodule

bind ddc_edid_ctrl ddc_edid_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .cmdQ(cmdQ), .statusQ(statusQ)
);

// File: tb/tb_ddc_edid_ctrl.sv
`timescale 1ns/1ps
module tb_ddc_edid_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0] portPresent = 4'b0101;
  logic edidWe = 1'b0;
  logic [6:0] edidAddr = '0;
  logic [7:0] edidData = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddc_edid_ctrl dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .portPresent(portPresent), .edidWe(edidWe), .edidAddr(edidAddr), .edidData(edidData)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] m;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] MA = 32'hFFFF_FFFF;
  localparam logic [31:0] MN = 32'hFFFF_FFEF;
  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 32'h0000_0005, MA, 8'd1},   // R1 status after reset
    '{1'b1, 2'd0, 32'h0000_0000, MA, 8'd1},   // R1
    '{1'b1, 2'd1, 32'h0000_0000, MA, 8'd1},   // R1
    '{1'b1, 2'd3, 32'h0000_0000, MA, 8'd1},   // R1
    '{1'b1, 2'd2, 32'h0000_0015, MA, 8'd9},   // R9 in-use set by prior read
    '{1'b0, 2'd2, 32'hFFFF_FFFF, MA, 8'd9},   // R9 only in-use is writable
    '{1'b1, 2'd2, 32'h0000_0005, MA, 8'd9},   // R9
    '{1'b0, 2'd0, 32'h0000_0001, MA, 8'd2},   // R2 select present port 1
    '{1'b1, 2'd0, 32'h0000_0001, MA, 8'd2},   // R2
    '{1'b1, 2'd2, 32'h0000_0003, MN, 8'd2},   // R2
    '{1'b0, 2'd1, 32'h4E08_00A1, MA, 8'd3},   // R3 sw-ready set in write
    '{1'b1, 2'd1, 32'h0E08_00A1, MA, 8'd3},   // R3
    '{1'b1, 2'd2, 32'h0000_010B, MN, 8'd4},   // R4 data phase, active
    '{1'b1, 2'd3, 32'h1811_0A03, MA, 8'd6},   // R6 bytes 0..3
    '{1'b1, 2'd3, 32'h342D_261F, MA, 8'd7},   // R7 last chunk
    '{1'b1, 2'd2, 32'h0000_000B, MN, 8'd7},   // R7 idle after stop cycle
    '{1'b1, 2'd3, 32'h342D_261F, MA, 8'd7},   // R7 nothing left
    '{1'b0, 2'd0, 32'h0000_0001, MA, 8'd2},   // R2
    '{1'b1, 2'd2, 32'h0000_0003, MN, 8'd2},   // R2 active cleared
    '{1'b0, 2'd1, 32'h0682_7EA1, MA, 8'd6},   // R6 indexed, start 126
    '{1'b1, 2'd3, 32'h0000_7C75, MA, 8'd8},   // R8 end of image
    '{1'b1, 2'd2, 32'h0000_020B, MN, 8'd7},   // R7 wait after no-stop cycle
    '{1'b0, 2'd0, 32'h0000_0003, MA, 8'd2},   // R2 port 3 present
    '{1'b0, 2'd1, 32'h0A04_0061, MA, 8'd8},   // R8 other target
    '{1'b1, 2'd3, 32'h0000_0000, MA, 8'd8},   // R8
    '{1'b1, 2'd2, 32'h0000_000B, MN, 8'd8},   // R8
    '{1'b0, 2'd0, 32'h0000_0002, MA, 8'd2},   // R2 port 2 absent
    '{1'b1, 2'd2, 32'h0000_0007, MN, 8'd2},   // R2 error set
    '{1'b0, 2'd1, 32'h0204_00A1, MA, 8'd8},   // R8 no EDID
    '{1'b1, 2'd3, 32'h0000_0000, MA, 8'd8},   // R8
    '{1'b1, 2'd2, 32'h0000_020F, MN, 8'd7},   // R7
    '{1'b0, 2'd1, 32'h0800_0000, MA, 8'd5},   // R5 stop after data cycle
    '{1'b1, 2'd2, 32'h0000_0007, MN, 8'd5},   // R5
    '{1'b0, 2'd1, 32'h0204_00A1, MA, 8'd4},   // R4
    '{1'b0, 2'd1, 32'h0000_0000, MA, 8'd5},   // R5 no cycle
    '{1'b0, 2'd1, 32'h0800_0000, MA, 8'd5},   // R5 stop with prior cycle 0
    '{1'b1, 2'd2, 32'h0000_010F, MN, 8'd5},   // R5 unchanged
    '{1'b0, 2'd1, 32'h0800_0000, MA, 8'd5},   // R5 stop with prior cycle 4
    '{1'b1, 2'd2, 32'h0000_0007, MN, 8'd5},   // R5
    '{1'b0, 2'd1, 32'h8000_0000, MA, 8'd10},  // R10 take interrupt-clear
    '{1'b0, 2'd1, 32'h8204_00A1, MA, 8'd10},  // R10 ignored while held
    '{1'b1, 2'd1, 32'h8000_0000, MA, 8'd10},  // R10
    '{1'b1, 2'd2, 32'h0000_0007, MN, 8'd10},  // R10
    '{1'b0, 2'd1, 32'h0000_0000, MA, 8'd10},  // R10 release resets
    '{1'b1, 2'd2, 32'h0000_0005, MA, 8'd10},  // R10
    '{1'b1, 2'd1, 32'h0000_0000, MA, 8'd10},  // R10
    '{1'b0, 2'd3, 32'hDEAD_BEEF, MA, 8'd11},  // R11 data write ignored
    '{1'b1, 2'd3, 32'h0000_0000, MA, 8'd11}   // R11 direction clear
  };

  function automatic logic [7:0] img(input int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      edidWe = 1'b1; edidAddr = 7'(i); edidData = img(i);
      @(negedge clk);
    end
    edidWe = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        busRd(VECS[i].a, r);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), r & VECS[i].m, VECS[i].d & VECS[i].m);
      end else begin
        busWr(VECS[i].a, VECS[i].d);
      end
    end

    // R6 R7: full sweep of the image, four bytes per read
    busWr(2'd0, 32'd1);
    busWr(2'd1, 32'h0E80_00A1);
    for (int k = 0; k < 32; k++) begin
      busRd(2'd3, r);
      check("R6 sweep", r, {img(4*k+3), img(4*k+2), img(4*k+1), img(4*k)});
    end
    busRd(2'd2, r);
    check("R7 sweep end idle", r & MN, 32'h0000_000B);

    // R8: start index at 128 reads zeros
    busWr(2'd0, 32'd1);
    busWr(2'd1, 32'h0684_80A1);
    busRd(2'd3, r);
    check("R8 past end", r, 32'h0);
    busRd(2'd2, r);
    check("R7 wait after past end", r & MN, 32'h0000_020B);

    // R6: index field ignored without index-enable
    busWr(2'd0, 32'd1);
    busWr(2'd1, 32'h0A08_40A1);
    busRd(2'd3, r);
    check("R6 no index", r, 32'h1811_0A03);

    // R1: reset in mid-transfer
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRd(2'd2, r);
    check("R1 status after reset", r, 32'h0000_0005);
    busRd(2'd1, r);
    check("R1 command after reset", r, 32'h0);
    busRd(2'd3, r);
    check("R1 data after reset", r, 32'h0);

    finishRun();
  end
endmodule